// File: doc/BRIEF.md
# Bit-Time Prescaled Timeout Counter

This block is a 16-bit down-counting timeout timer for a CAN-style protocol controller. The bit-timing logic sends it a single-cycle pulse once per nominal bit time. A 4-bit divider setting turns that pulse stream into decrement steps, one step for every 1 to 16 pulses. A mode setting decides what starts the count again from its programmed reload value. The choices are a software write strobe alone, that strobe or a restart pulse from the protocol side, or no counting at all.

When a decrement takes the count to zero, the counter stops and stays at zero. At the same clock edge it sets a sticky interrupt flag, which software clears by writing a one. The live count can be read at any time. There are no data streams here. Every pin is a plain control or status level, or a single-cycle strobe, so the block has no valid/ready handshake and no back-pressure.

Top module: `bt_timeout_timer`

## Requirements
- R1: While reset is asserted, `count` reads 0xFFFF, `timeout_irq` reads 0 and the divider phase is zero.
- R2: `cfg_prescale` holds N-1. Value 0 divides by 1 and value 15 divides by 16. After a restart, the count drops by exactly one on every N-th `bit_tick`.
- R3: The count changes only on a cycle with `bit_tick` high, or on a reload. With no tick and no reload it holds its value indefinitely.
- R4: `timeout_irq` rises at the same clock edge at which a decrement makes the count 0.
- R5: Once a decrement has made the count 0, further ticks leave it at 0 until the next reload.
- R6: `timeout_irq` stays set until `flag_clr` is pulsed. When a set and a clear arrive in the same cycle, the set wins.
- R7: In mode 2'b00 (off), and in the reserved mode 2'b11, `count` takes `cfg_reload` one cycle later and follows it. No decrement happens and the flag is not set.
- R8: In mode 2'b01 (continuous), either `sw_restart` or `evt_restart` reloads the count from `cfg_reload` and clears the divider phase.
- R9: In mode 2'b10 (write-only), `evt_restart` has no effect, and only `sw_restart` reloads the count.
- R10: When a restart and a decrement step fall in the same cycle, the restart wins and the count becomes `cfg_reload`.
- R11: A restart clears any partial divider phase. A full N ticks are then needed before the next decrement.
- R12: A restart with `cfg_reload` = 0 leaves the count at 0 and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per nominal bit time |
| cfg_mode | input | 2 | 00 off, 01 continuous, 10 write-only, 11 reserved (acts as off) |
| cfg_prescale | input | 4 | Divide ratio minus one |
| cfg_reload | input | 16 | Value loaded on start or restart |
| sw_restart | input | 1 | Software write strobe to the counter |
| evt_restart | input | 1 | Restart pulse from protocol logic |
| flag_clr | input | 1 | Write-one-to-clear strobe for the timeout flag |
| count | output | 16 | Live count value |
| timeout_irq | output | 1 | Sticky timeout interrupt flag |

## Verification
The embedded assertions check several rules on every cycle:
- the count moves only by a single decrement or by a reload;
- zero is held once reached;
- any reload, including a restart that meets a step, lands on the reload value;
- the flag rises only with a zero count and stays set until cleared.

Other behaviours need the bench's scenarios because they depend on a sequence of stimulus:
- the exact divide ratio for each prescale setting;
- the loss of a partial divider phase at a restart;
- which restart source each mode honours;
- set-over-clear priority on the flag.

// File: rtl/tot_pkg.sv
package tot_pkg;
  typedef enum logic [1:0] {
    TOT_OFF   = 2'b00,
    TOT_CONT  = 2'b01,
    TOT_WRITE = 2'b10,
    TOT_RSVD  = 2'b11
  } tot_mode_e;
endpackage

// File: rtl/tot_prescaler.sv
module tot_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             clear,
  input  logic [PRE_W-1:0] div_sel,
  output logic             step
);
  generate
    if (PRE_W == 0) begin : g_direct
      assign step = tick && enable && !clear;
    end else begin : g_phase
      logic [PRE_W-1:0] phase;
      logic             at_end;

      assign at_end = (phase >= div_sel);
      assign step   = tick && enable && !clear && at_end;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase <= '0;
        end else if (clear) begin
          phase <= '0;
        end else if (tick && enable) begin
          phase <= at_end ? '0 : phase + 1'b1;
        end
      end

      // R11: a clear always leaves the phase at zero
      assert_phase_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (phase == '0));
    end
  endgenerate
endmodule

// File: rtl/tot_down_counter.sv
module tot_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] RST_VAL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  logic is_zero;
  assign is_zero = (count == '0);
  assign expire  = step && !load && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= RST_VAL;
    end else if (load) begin
      count <= load_val;
    end else if (step && !is_zero) begin
      count <= count - ONE;
    end
  end

  // R2: a step on a nonzero count lowers it by exactly one
  assert_dec_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !is_zero) |=> (count == $past(count) - ONE));

  // R3: without a step or a load the count holds
  assert_hold_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(count));

  // R5: zero is held until a load
  assert_zero_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_zero && !load) |=> (count == '0));
endmodule

// File: rtl/tot_irq_flag.sv
module tot_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  // R6: the flag stays set until a clear arrives
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // R6: a set in the same cycle as a clear leaves the flag high
  assert_set_beats_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set && clr) |=> flag);
endmodule

// File: rtl/bt_timeout_timer.sv
module bt_timeout_timer
  import tot_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic [1:0]       cfg_mode,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [CNT_W-1:0] cfg_reload,
  input  logic             sw_restart,
  input  logic             evt_restart,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             timeout_irq
);
  tot_mode_e mode;
  logic      hold;
  logic      restart;
  logic      load;
  logic      running;
  logic      step;
  logic      expire;

  assign mode    = tot_mode_e'(cfg_mode);
  assign hold    = (mode == TOT_OFF) || (mode == TOT_RSVD);
  assign restart = sw_restart || (evt_restart && (mode == TOT_CONT));
  assign load    = hold || restart;
  assign running = !load && (count != '0);

  tot_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (bit_tick),
    .enable  (running),
    .clear   (load),
    .div_sel (cfg_prescale),
    .step    (step)
  );

  tot_down_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (cfg_reload),
    .step     (step),
    .count    (count),
    .expire   (expire)
  );

  tot_irq_flag i_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (expire),
    .clr   (flag_clr),
    .flag  (timeout_irq)
  );

  // R4: the flag rises only together with a zero count
  assert_flag_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_irq) |-> (count == '0));

  // R10: any restart lands on the reload value, whatever the tick does
  assert_restart_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == $past(cfg_reload)));

  // R7: off or reserved mode tracks the reload value and never raises the flag
  assert_off_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ((count == $past(cfg_reload)) && !$rose(timeout_irq)));

  // R9: in write-only mode a lone protocol restart does not reload a nonzero count
  assert_evt_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == TOT_WRITE) && evt_restart && !sw_restart && !bit_tick) |=> $stable(count));
endmodule

// File: tb/test_bt_timeout_timer.sv
module test_bt_timeout_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic [3:0]  cfg_prescale = 4'd0;
  logic [15:0] cfg_reload = 16'd0;
  logic        sw_restart = 1'b0;
  logic        evt_restart = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] count;
  logic        timeout_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bt_timeout_timer i_bt_timeout_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .cfg_mode     (cfg_mode),
    .cfg_prescale (cfg_prescale),
    .cfg_reload   (cfg_reload),
    .sw_restart   (sw_restart),
    .evt_restart  (evt_restart),
    .flag_clr     (flag_clr),
    .count        (count),
    .timeout_irq  (timeout_irq)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  pre;
    logic [15:0] rel;
    logic [7:0]  ticks;
    logic [15:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 4'd0,  16'd10,   8'd3,  16'd7,    1'b0},
    '{2'b01, 4'd3,  16'd10,   8'd9,  16'd8,    1'b0},
    '{2'b10, 4'd15, 16'd5,    8'd33, 16'd3,    1'b0},
    '{2'b01, 4'd1,  16'd3,    8'd6,  16'd0,    1'b1},
    '{2'b01, 4'd0,  16'd2,    8'd5,  16'd0,    1'b1},
    '{2'b10, 4'd2,  16'd100,  8'd30, 16'd90,   1'b0},
    '{2'b01, 4'd0,  16'd0,    8'd2,  16'd0,    1'b0},
    '{2'b00, 4'd0,  16'd1234, 8'd5,  16'd1234, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick_once();
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick_once();
  endtask

  task automatic restart_sw();
    sw_restart = 1'b1;
    flag_clr   = 1'b1;
    @(negedge clk);
    sw_restart = 1'b0;
    flag_clr   = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 count in reset", 32'(count), 32'hFFFF);
    chk("R1 flag in reset", 32'(timeout_irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 ratios, R4/R5 expiry, R7 off, R9 write-only, R12 zero reload
    for (int v = 0; v < NV; v++) begin
      cfg_mode     = VECS[v].mode;
      cfg_prescale = VECS[v].pre;
      cfg_reload   = VECS[v].rel;
      restart_sw();
      ticks(int'(VECS[v].ticks));
      chk($sformatf("R2 vector %0d count", v), 32'(count), 32'(VECS[v].exp_cnt));
      chk($sformatf("R4 R12 vector %0d flag", v), 32'(timeout_irq), 32'(VECS[v].exp_flag));
    end

    // R3: no tick, no change
    cfg_mode = 2'b01; cfg_prescale = 4'd0; cfg_reload = 16'd50;
    restart_sw();
    repeat (10) @(negedge clk);
    chk("R3 hold without tick", 32'(count), 32'd50);

    // R8: protocol restart honoured in continuous mode
    ticks(5);
    chk("R8 pre-restart count", 32'(count), 32'd45);
    evt_restart = 1'b1; @(negedge clk); evt_restart = 1'b0;
    chk("R8 evt restart reloads", 32'(count), 32'd50);

    // R9: protocol restart ignored in write-only mode
    cfg_mode = 2'b10;
    ticks(3);
    evt_restart = 1'b1; @(negedge clk); evt_restart = 1'b0;
    chk("R9 evt restart ignored", 32'(count), 32'd47);
    sw_restart = 1'b1; @(negedge clk); sw_restart = 1'b0;
    chk("R9 sw restart reloads", 32'(count), 32'd50);

    // R10: restart and step in the same cycle
    ticks(2);
    chk("R10 before collision", 32'(count), 32'd48);
    bit_tick = 1'b1; sw_restart = 1'b1; @(negedge clk);
    bit_tick = 1'b0; sw_restart = 1'b0;
    chk("R10 restart wins", 32'(count), 32'd50);

    // R11: restart drops a partial divider phase
    cfg_mode = 2'b01; cfg_prescale = 4'd3;
    restart_sw();
    ticks(3);
    restart_sw();
    ticks(3);
    chk("R11 no step after 3 ticks", 32'(count), 32'd50);
    tick_once();
    chk("R11 step on 4th tick", 32'(count), 32'd49);

    // R4: flag rises at the same edge the count reaches zero
    cfg_prescale = 4'd0; cfg_reload = 16'd1;
    restart_sw();
    chk("R4 count before expiry", 32'(count), 32'd1);
    chk("R4 flag before expiry", 32'(timeout_irq), 32'd0);
    bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0;
    chk("R4 count at expiry", 32'(count), 32'd0);
    chk("R4 flag at expiry", 32'(timeout_irq), 32'd1);

    // R5: stays at zero
    ticks(4);
    chk("R5 zero held", 32'(count), 32'd0);

    // R6: sticky flag, clear, set-over-clear
    repeat (5) @(negedge clk);
    chk("R6 flag sticky", 32'(timeout_irq), 32'd1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R6 flag cleared", 32'(timeout_irq), 32'd0);
    restart_sw();
    bit_tick = 1'b1; flag_clr = 1'b1; @(negedge clk);
    bit_tick = 1'b0; flag_clr = 1'b0;
    chk("R6 set beats clear", 32'(timeout_irq), 32'd1);

    // R7: reserved mode behaves as off
    flag_clr = 1'b1; cfg_mode = 2'b11; cfg_reload = 16'd777; @(negedge clk);
    flag_clr = 1'b0;
    chk("R7 reserved follows reload", 32'(count), 32'd777);
    ticks(3);
    chk("R7 reserved no decrement", 32'(count), 32'd777);
    chk("R7 reserved no flag", 32'(timeout_irq), 32'd0);

    finish_run();
  end
endmodule